// File: doc/BRIEF.md
# Fine and Coarse Thread Selector

This block decides, in every cycle, which of several hardware thread contexts may issue one instruction into a shared pipeline. Each context owns a program counter. Every cycle the block receives, for each thread, a short-stall level and a long-stall pulse. The long-stall pulse stands for a miss in the second-level cache. A mode input chooses between two switching policies.

In fine mode the issue slot rotates round-robin. Any thread that cannot issue is passed over, so instructions from different threads interleave cycle by cycle. In coarse mode one thread owns the pipeline and keeps issuing until it takes a long stall. The block then hands the pipeline to another thread and pays a fixed refill penalty before the new owner issues. The selected thread, an issue-valid flag, the issuing PC and a switch flag all come out in the same cycle as the stall inputs that produced them.

Top module: `mt_thread_sel`

## Requirements
- R1: While reset is held, and directly after it, every PC is zero and the selected thread is thread 0; the first issue after reset comes from thread 0 at PC 0.
- R2: In fine mode (coarseMode=0) a thread is eligible when its stallIn bit is low and it is not long-blocked. The issuing thread is the first eligible one in increasing index order, wrapping, starting at the thread after the last thread that issued (starting at thread 0 after reset).
- R3: In fine mode, stalled threads are skipped. When no thread is eligible, issueValid is low and issueTid shows the last issuing thread.
- R4: On an issue, issuePc shows the selected thread's PC before the issue, and that PC then grows by 4. The PCs of all other threads keep their values.
- R5: A longMissIn pulse on a thread blocks it in the pulse cycle and in the LONG_LAT cycles that follow. A new pulse restarts the wait.
- R6: In coarse mode (coarseMode=1) the owner thread issues in every cycle its stallIn is low. A short stall of the owner gives an empty slot and no switch.
- R7: In coarse mode, when the owner is long-blocked and another thread is not, switchEvent is high for one cycle with no issue. The new owner is the first thread after the old owner, in wrapping index order, that is not long-blocked. In the PENALTY (3) cycles that follow, nothing issues and issueTid shows the new owner. Leaving coarse mode ends the penalty at once.
- R8: In coarse mode, when the owner and every other thread are long-blocked, no switch occurs and nothing issues. The owner resumes when its wait ends.
- R9: In fine mode, switchEvent is high exactly in the cycles where an issue comes from a thread other than the last issuing thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| coarseMode | input | 1 | 1 = coarse switching, 0 = fine rotation |
| stallIn | input | THREADS | Per-thread short stall, level |
| longMissIn | input | THREADS | Per-thread long stall, pulse starts a LONG_LAT wait |
| issueValid | output | 1 | An instruction issues this cycle |
| issueTid | output | TID_W | Selected thread |
| switchEvent | output | 1 | Thread switch in this cycle |
| issuePc | output | PC_W | PC of the selected thread |

## Verification
Fine rotation is first run with no stalls, which shows the round-robin order and the PC steps. Sparse and then full stall masks follow; these separate skipping from an empty slot, and show a single ready thread issuing again. A long-miss pulse in fine mode shows the exact length of the wait. In coarse mode, the owner's short stalls are set against its long stalls to tell an empty slot apart from a switch and its penalty. Long stalls on all threads at once exercise the case where no switch is possible. A return to fine mode during a penalty checks that the penalty is cut short.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  parameter int unsigned THREADS = 4;
  localparam int unsigned TID_W = (THREADS > 1) ? $clog2(THREADS) : 1;

  typedef logic [TID_W-1:0] tid_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;
    tid_t tid;
  } dp_strobe_t;

  typedef enum logic {PH_RUN, PH_REFILL} phase_e;
endpackage

// File: rtl/tsel_wait.sv
module tsel_wait
  import tsel_pkg::*;
#(
  parameter int unsigned LONG_LAT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [THREADS-1:0] longMissIn,
  output logic [THREADS-1:0] longBusy
);
  localparam int unsigned CNT_W = $clog2(LONG_LAT + 1);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] waitCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        waitCnt <= '0;
      end else if (longMissIn[t]) begin
        waitCnt <= CNT_W'(LONG_LAT);
      end else if (waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end

    assign longBusy[t] = longMissIn[t] | (waitCnt != '0);
  end
endmodule

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
#(
  parameter int unsigned PENALTY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               coarseMode,
  input  logic [THREADS-1:0] stallIn,
  input  logic [THREADS-1:0] longBusy,
  output dp_strobe_t         strobe,
  output logic               issueValid,
  output logic               switchEvent,
  output tid_t               selTid
);
  localparam int unsigned REF_W = (PENALTY > 0) ? $clog2(PENALTY + 1) : 1;

  tid_t             curTid;
  tid_t             startPtr;
  phase_e           phase;
  logic [REF_W-1:0] refillCnt;

  logic [THREADS-1:0] fineElig;
  logic               fineFound;
  tid_t               fineTid;
  logic               coarseFound;
  tid_t               coarseTid;
  logic               doSwitch;
  tid_t               nextStart;

  assign fineElig = ~stallIn & ~longBusy;

  // round-robin scan from startPtr; lowest offset wins
  always_comb begin
    int idx;
    fineFound = 1'b0;
    fineTid   = curTid;
    for (int k = THREADS - 1; k >= 0; k--) begin
      idx = (int'(startPtr) + k) % THREADS;
      if (fineElig[idx]) begin
        fineFound = 1'b1;
        fineTid   = tid_t'(idx);
      end
    end
  end

  // successor of the owner that is not long-blocked
  always_comb begin
    int idx;
    coarseFound = 1'b0;
    coarseTid   = curTid;
    for (int k = THREADS - 1; k >= 1; k--) begin
      idx = (int'(curTid) + k) % THREADS;
      if (!longBusy[idx]) begin
        coarseFound = 1'b1;
        coarseTid   = tid_t'(idx);
      end
    end
  end

  always_comb begin
    issueValid  = 1'b0;
    switchEvent = 1'b0;
    doSwitch    = 1'b0;
    selTid      = curTid;
    if (!coarseMode) begin
      if (fineFound) begin
        issueValid  = 1'b1;
        selTid      = fineTid;
        switchEvent = (fineTid != curTid);
      end
    end else if (phase == PH_RUN) begin
      if (longBusy[curTid]) begin
        if (coarseFound) begin
          doSwitch    = 1'b1;
          switchEvent = 1'b1;
        end
      end else if (!stallIn[curTid]) begin
        issueValid = 1'b1;
      end
    end
  end

  assign nextStart    = tid_t'((int'(selTid) + 1) % THREADS);
  assign strobe.issue = issueValid;
  assign strobe.tid   = selTid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTid    <= '0;
      startPtr  <= '0;
      phase     <= PH_RUN;
      refillCnt <= '0;
    end else begin
      if (issueValid) begin
        curTid   <= selTid;
        startPtr <= nextStart;
      end
      if (doSwitch) begin
        curTid    <= coarseTid;
        phase     <= (PENALTY > 0) ? PH_REFILL : PH_RUN;
        refillCnt <= REF_W'(PENALTY);
      end else if (!coarseMode) begin
        phase <= PH_RUN;
      end else if (phase == PH_REFILL) begin
        refillCnt <= refillCnt - 1'b1;
        if (refillCnt == REF_W'(1)) phase <= PH_RUN;
      end
    end
  end
endmodule

// File: rtl/tsel_dp.sv
module tsel_dp
  import tsel_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  dp_strobe_t      strobe,
  output logic [PC_W-1:0] issuePc
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic [PC_W-1:0] pcReg [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_pc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pcReg[t] <= '0;
      end else if (strobe.issue && (strobe.tid == tid_t'(t))) begin
        pcReg[t] <= pcReg[t] + PC_STEP;
      end
    end
  end

  assign issuePc = pcReg[strobe.tid];
endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel
  import tsel_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PENALTY  = 3,
  parameter int unsigned LONG_LAT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               coarseMode,
  input  logic [THREADS-1:0] stallIn,
  input  logic [THREADS-1:0] longMissIn,
  output logic               issueValid,
  output logic [TID_W-1:0]   issueTid,
  output logic               switchEvent,
  output logic [PC_W-1:0]    issuePc
);
  logic [THREADS-1:0] longBusy;
  dp_strobe_t         strobe;
  tid_t               selTid;

  tsel_wait #(.LONG_LAT(LONG_LAT)) u_wait (
    .clk(clk), .rstN(rstN), .longMissIn(longMissIn), .longBusy(longBusy)
  );

  tsel_ctrl #(.PENALTY(PENALTY)) u_ctrl (
    .clk(clk), .rstN(rstN), .coarseMode(coarseMode), .stallIn(stallIn),
    .longBusy(longBusy), .strobe(strobe), .issueValid(issueValid),
    .switchEvent(switchEvent), .selTid(selTid)
  );

  tsel_dp #(.PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issuePc(issuePc)
  );

  assign issueTid = selTid;
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker
  import tsel_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               coarseMode,
  input logic [THREADS-1:0] stallIn,
  input logic [THREADS-1:0] longMissIn,
  input logic               issueValid,
  input logic [TID_W-1:0]   issueTid,
  input logic               switchEvent
);
  // R3: an issuing thread never has its short stall raised
  p_no_stalled_issue_r3: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !stallIn[issueTid]);

  // R5: a thread pulsing a long miss cannot issue in that cycle
  p_no_miss_issue_r5: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !longMissIn[issueTid]);

  // R7: the switch cycle is an empty slot in coarse mode
  p_switch_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coarseMode && switchEvent) |-> !issueValid);

  // R7: the cycle after a coarse switch is a refill bubble and names a new thread
  p_refill_bubble_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coarseMode && switchEvent) |=> (!coarseMode || !issueValid));

  p_new_owner_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coarseMode && switchEvent) |=> (issueTid != $past(issueTid)));

  // R6: without a switch, consecutive coarse issues come from one thread
  p_owner_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (coarseMode && $past(coarseMode) && !$past(switchEvent) &&
     issueValid && $past(issueValid)) |-> (issueTid == $past(issueTid)));
endmodule

bind mt_thread_sel tsel_checker u_chk (
  .clk(clk), .rstN(rstN), .coarseMode(coarseMode), .stallIn(stallIn),
  .longMissIn(longMissIn), .issueValid(issueValid), .issueTid(issueTid),
  .switchEvent(switchEvent)
);

// File: tb/mt_thread_sel_tb.sv
`timescale 1ns/1ps
module mt_thread_sel_tb;
  import tsel_pkg::*;

  localparam int NT  = THREADS;
  localparam int PEN = 3;
  localparam int LAT = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          coarseMode = 1'b0;
  logic [NT-1:0] stallIn = '1;
  logic [NT-1:0] longMissIn = '0;
  logic          issueValid;
  logic [TID_W-1:0] issueTid;
  logic          switchEvent;
  logic [31:0]   issuePc;

  always #2 clk = ~clk;

  mt_thread_sel #(.PC_W(32), .PENALTY(PEN), .LONG_LAT(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .coarseMode(coarseMode), .stallIn(stallIn),
    .longMissIn(longMissIn), .issueValid(issueValid), .issueTid(issueTid),
    .switchEvent(switchEvent), .issuePc(issuePc)
  );

  typedef struct {
    logic        v;
    int          tid;
    logic        sw;
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t q[$];
  event sampleEv;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference state
  int          mCur, mStart, mRefill;
  int          mWait [NT];
  logic [31:0] mPc [NT];

  // monitor: compare the design against the next expected item
  initial begin
    exp_t e;
    forever begin
      @(sampleEv);
      e = q.pop_front();
      checks++;
      if (issueValid !== e.v || int'(issueTid) != e.tid ||
          switchEvent !== e.sw || issuePc !== e.pc) begin
        errors++;
        $display("FAIL %s valid=%b/%b tid=%0d/%0d sw=%b/%b pc=%0h/%0h",
                 e.tag, issueValid, e.v, issueTid, e.tid,
                 switchEvent, e.sw, issuePc, e.pc);
      end
    end
  end

  task automatic modelReset();
    mCur = 0; mStart = 0; mRefill = 0;
    for (int t = 0; t < NT; t++) begin mWait[t] = 0; mPc[t] = '0; end
  endtask

  // driver: apply one cycle of stimulus and push its expected result
  task automatic step(input logic c, input logic [NT-1:0] s,
                      input logic [NT-1:0] m, input string tag);
    exp_t e;
    bit   busy [NT];
    int   newOwner;
    bit   doSw;
    @(negedge clk);
    coarseMode = c; stallIn = s; longMissIn = m;
    for (int t = 0; t < NT; t++) busy[t] = m[t] || (mWait[t] > 0);
    e.v = 1'b0; e.tid = mCur; e.sw = 1'b0; e.tag = tag;
    doSw = 0; newOwner = mCur;
    if (!c) begin
      mRefill = 0;
      for (int k = 0; k < NT; k++) begin
        int i = (mStart + k) % NT;
        if (!e.v && !s[i] && !busy[i]) begin e.v = 1'b1; e.tid = i; end
      end
      e.sw = e.v && (e.tid != mCur);
    end else if (mRefill > 0) begin
      mRefill--;
    end else if (busy[mCur]) begin
      for (int k = 1; k < NT; k++) begin
        int i = (mCur + k) % NT;
        if (!doSw && !busy[i]) begin doSw = 1; newOwner = i; end
      end
      e.sw = doSw;
    end else if (!s[mCur]) begin
      e.v = 1'b1;
    end
    e.pc = mPc[e.tid];
    q.push_back(e);
    #1 ->sampleEv;
    if (e.v) begin
      mPc[e.tid] = mPc[e.tid] + 32'd4;
      mCur = e.tid;
      mStart = (e.tid + 1) % NT;
    end
    if (doSw) begin mCur = newOwner; mRefill = PEN; end
    for (int t = 0; t < NT; t++) begin
      if (m[t]) mWait[t] = LAT;
      else if (mWait[t] > 0) mWait[t]--;
    end
  endtask

  function automatic logic [NT-1:0] ownerMask();
    return NT'(1) << mCur;
  endfunction

  initial begin
    exp_t e;
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state with every thread stalled
    e.v = 1'b0; e.tid = 0; e.sw = 1'b0; e.pc = '0; e.tag = "R1 reset";
    q.push_back(e);
    #1 ->sampleEv;
    @(negedge clk);
    rstN = 1'b1;

    step(0, 4'b0000, 4'b0000, "R1 first issue");
    repeat (7) step(0, 4'b0000, 4'b0000, "R2 rotation");
    repeat (2) step(0, 4'b0000, 4'b0000, "R4 pc step");

    step(0, 4'b0010, 4'b0000, "R3 skip one");
    step(0, 4'b0110, 4'b0000, "R3 skip two");
    step(0, 4'b1111, 4'b0000, "R3 none ready");
    step(0, 4'b1110, 4'b0000, "R3 single ready");
    step(0, 4'b1110, 4'b0000, "R3 single again");

    step(0, 4'b0000, 4'b0100, "R5 miss pulse");
    repeat (8) step(0, 4'b0000, 4'b0000, "R5 wait");

    repeat (3) step(1, 4'b0000, 4'b0000, "R6 owner issues");
    repeat (2) step(1, 4'b1111, 4'b0000, "R6 short stall");
    repeat (2) step(1, 4'b0000, 4'b0000, "R6 resume");

    step(1, 4'b0000, ownerMask(), "R7 owner miss");
    repeat (6) step(1, 4'b0000, 4'b0000, "R7 refill");
    step(1, 4'b0000, ownerMask(), "R7 second miss");
    step(1, 4'b0000, 4'b0000, "R7 refill");
    repeat (3) step(0, 4'b0000, 4'b0000, "R7 leave coarse");

    repeat (4) step(1, 4'b0000, 4'b0000, "R8 settle");
    step(1, 4'b0000, 4'b1111, "R8 all miss");
    repeat (8) step(1, 4'b0000, 4'b0000, "R8 owner waits");

    repeat (4) step(0, 4'b0101, 4'b0000, "R9 fine switch");
    repeat (2) step(0, 4'b1011, 4'b0000, "R9 same thread");

    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule